// File: doc/BRIEF.md
# Per-Slot Conversion Limit Monitor

This block watches the stream of conversion results coming out of an analog-to-digital converter and decides, for every result, whether it lies outside a window defined for the sample slot that produced it. Eight slots are supported. Each slot owns an upper threshold and a lower threshold. A result above its slot's upper threshold or below its slot's lower threshold latches a flag, and the flag stays latched until software clears it explicitly.

Software reaches the thresholds, two interrupt enables and the flag word through a small register port. Register writes take effect on the clock edge. Reads are combinational from the address. The flag word is also driven directly on an output. A level interrupt line is raised while an enabled group has any flag set.

Register map (word addresses): 0 to 7 hold the upper threshold of slots 0 to 7. 8 to 15 hold the lower threshold of slots 0 to 7. 16 is the control word, with bit 0 enabling the upper-flag interrupt and bit 1 enabling the lower-flag interrupt. 17 is the flag word. Threshold registers are 12 bits wide, and their upper four read bits are zero.

Top module: `adc_limit_guard`

## Requirements
- R1: A result is compared only against the two thresholds of the slot given by `res_slot`; the flags of other slots are unaffected.
- R2: An upper flag is set when the result is strictly greater than the slot's upper threshold. Equality does not set it.
- R3: A lower flag is set when the result is strictly less than the slot's lower threshold. Equality does not set it.
- R4: Flags are sticky. A later in-range result never clears a flag that is already set.
- R5: A write to address 17 clears exactly the flags whose bit in `reg_wdata` is 1. Flag bits written with 0 keep their value.
- R6: In the flag word, upper flags sit in bits 15..8 and lower flags in bits 7..0, with slot n at bit n of each byte. A read of address 17 returns the same value as the `status` output.
- R7: `irq` equals the OR of (any upper flag AND control bit 0) and (any lower flag AND control bit 1).
- R8: When a new violation and a clearing write hit the same flag in one cycle, the flag ends up set. Other bits in the same write are still cleared.
- R9: After reset all flags and both enables are 0, every upper threshold reads 0xFFF and every lower threshold reads 0. In this state no result can set a flag.
- R10: A flag becomes visible on `status` at the clock edge that samples `res_valid`, and not before that edge.
- R11: Threshold and control registers read back the value last written, truncated to their width, with unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion result strobe |
| res_slot | input | 3 | Sample slot of the result |
| res_data | input | 12 | Conversion result |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| status | output | 16 | Flag word |
| irq | output | 1 | Level interrupt |

## Verification
Every slot is programmed with a distinct window and fed the values one below and at each threshold, one above the upper threshold, a midpoint, and the two rails. These inputs separate strict from non-strict comparison and expose wrong slot or byte mapping. Sequences of an out-of-range result followed by an in-range one, partial clearing masks and zero-valued clears separate sticky flags from flags that follow the last result. A violation that coincides with a clearing write checks that set wins over clear, and walking the enables over mixed upper and lower flags checks the gating of the interrupt.

// File: rtl/alg_pkg.sv
package alg_pkg;
  localparam int SLOTS  = 8;
  localparam int RES_W  = 12;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int FLAG_W = 2 * SLOTS;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2 * SLOTS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2 * SLOTS + 1);

  function automatic logic beyond_high(input logic [RES_W-1:0] r,
                                       input logic [RES_W-1:0] lim);
    return r > lim;
  endfunction

  function automatic logic beyond_low(input logic [RES_W-1:0] r,
                                      input logic [RES_W-1:0] lim);
    return r < lim;
  endfunction

  function automatic logic merge_irq(input logic [FLAG_W-1:0] f,
                                     input logic en_h, input logic en_l);
    return (en_h && (|f[FLAG_W-1:SLOTS])) || (en_l && (|f[SLOTS-1:0]));
  endfunction

  function automatic logic [FLAG_W-1:0] next_flags(input logic [FLAG_W-1:0] cur,
                                                   input logic [FLAG_W-1:0] set,
                                                   input logic [FLAG_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/limit_regfile.sv
module limit_regfile
  import alg_pkg::*;
#(
  parameter int N_SLOT = SLOTS,
  parameter int RW     = RES_W,
  parameter int AW     = ADDR_W,
  parameter int DW     = DATA_W,
  localparam int SW    = $clog2(N_SLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] look_slot,
  output logic [RW-1:0] sel_hi,
  output logic [RW-1:0] sel_lo,
  output logic          en_hi,
  output logic          en_lo,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] CTRL_A = AW'(2 * N_SLOT);

  logic [RW-1:0] hi_q [N_SLOT];
  logic [RW-1:0] lo_q [N_SLOT];
  logic [1:0]    en_q;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic wr_hi, wr_lo;
    assign wr_hi = wr && (addr == AW'(g));
    assign wr_lo = wr && (addr == AW'(N_SLOT + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= '1;
        lo_q[g] <= '0;
      end else begin
        if (wr_hi) hi_q[g] <= wdata[RW-1:0];
        if (wr_lo) lo_q[g] <= wdata[RW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      en_q <= 2'b00;
    else if (wr && addr == CTRL_A)   en_q <= wdata[1:0];
  end

  assign sel_hi = hi_q[look_slot];
  assign sel_lo = lo_q[look_slot];
  assign en_hi  = en_q[0];
  assign en_lo  = en_q[1];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (addr == AW'(i))          rdata = DW'(hi_q[i]);
      if (addr == AW'(N_SLOT + i)) rdata = DW'(lo_q[i]);
    end
    if (addr == CTRL_A) rdata = DW'(en_q);
  end
endmodule

// File: rtl/limit_compare.sv
module limit_compare
  import alg_pkg::*;
#(
  parameter int N_SLOT = SLOTS,
  localparam int SW    = $clog2(N_SLOT),
  localparam int FW    = 2 * N_SLOT
) (
  input  logic             valid,
  input  logic [SW-1:0]    slot,
  input  logic [RES_W-1:0] data,
  input  logic [RES_W-1:0] sel_hi,
  input  logic [RES_W-1:0] sel_lo,
  output logic [FW-1:0]    set_mask
);
  logic over, under;
  assign over  = beyond_high(data, sel_hi);
  assign under = beyond_low(data, sel_lo);

  for (genvar g = 0; g < N_SLOT; g++) begin : g_hit
    logic mine;
    assign mine                = valid && (slot == SW'(g));
    assign set_mask[N_SLOT+g]  = mine && over;
    assign set_mask[g]         = mine && under;
  end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags
  import alg_pkg::*;
#(
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] set_mask,
  input  logic [FW-1:0] clr_mask,
  output logic [FW-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= next_flags(flags, set_mask, clr_mask);
  end
endmodule

// File: rtl/adc_limit_guard.sv
module adc_limit_guard
  import alg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [SLOT_W-1:0] res_slot,
  input  logic [RES_W-1:0]  res_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [FLAG_W-1:0] status,
  output logic              irq
);
  logic [RES_W-1:0]  sel_hi, sel_lo;
  logic              en_hi, en_lo;
  logic [DATA_W-1:0] rf_rdata;
  logic [FLAG_W-1:0] set_mask, clr_mask, flags;

  limit_regfile #(.N_SLOT(SLOTS), .RW(RES_W), .AW(ADDR_W), .DW(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .look_slot(res_slot), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .en_hi(en_hi), .en_lo(en_lo), .rdata(rf_rdata)
  );

  limit_compare #(.N_SLOT(SLOTS)) u_cmp (
    .valid(res_valid), .slot(res_slot), .data(res_data),
    .sel_hi(sel_hi), .sel_lo(sel_lo), .set_mask(set_mask)
  );

  assign clr_mask = (reg_wr && reg_addr == A_STAT) ? reg_wdata[FLAG_W-1:0] : '0;

  sticky_flags #(.FW(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask), .flags(flags)
  );

  assign status    = flags;
  assign irq       = merge_irq(flags, en_hi, en_lo);
  assign reg_rdata = (reg_addr == A_STAT) ? DATA_W'(flags) : rf_rdata;
endmodule

// File: rtl/adc_limit_guard_chk.sv
module adc_limit_guard_chk
  import alg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [SLOT_W-1:0] res_slot,
  input logic [RES_W-1:0]  res_data,
  input logic [RES_W-1:0]  sel_hi,
  input logic [RES_W-1:0]  sel_lo,
  input logic [FLAG_W-1:0] clr_mask,
  input logic [FLAG_W-1:0] set_mask,
  input logic [FLAG_W-1:0] status,
  input logic              en_hi,
  input logic              en_lo,
  input logic              irq
);
  // R2, R8: an upper violation is present on the next cycle regardless of clears
  a_r2_high_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(res_valid && (res_data > sel_hi)) |-> status[SLOTS + int'($past(res_slot))]);

  // R3, R8: a lower violation is present on the next cycle
  a_r3_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(res_valid && (res_data < sel_lo)) |-> status[int'($past(res_slot))]);

  // R4: a set flag only falls when a clear was written for it
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~$past(clr_mask) & ~status) == '0));

  // R5: a cleared bit with no concurrent set reads 0
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr_mask) & ~$past(set_mask) & status) == '0));

  // R1: at most one slot's pair of flags can be newly raised per result
  a_r1_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(set_mask) <= 2);

  // R7: interrupt line follows enabled flag groups
  a_r7_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((en_hi && status[FLAG_W-1:SLOTS] != '0) || (en_lo && status[SLOTS-1:0] != '0)));
endmodule

bind adc_limit_guard adc_limit_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_slot(res_slot),
  .res_data(res_data), .sel_hi(sel_hi), .sel_lo(sel_lo), .clr_mask(clr_mask),
  .set_mask(set_mask), .status(status), .en_hi(en_hi), .en_lo(en_lo), .irq(irq)
);

// File: tb/tb_adc_limit_guard.sv
module tb_adc_limit_guard;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        res_valid = 0;
  logic [2:0]  res_slot = 0;
  logic [11:0] res_data = 0;
  logic        reg_wr = 0;
  logic [4:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [15:0] status;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_st;
  int hi_v [8];
  int lo_v [8];

  always #2 clk = ~clk;

  adc_limit_guard dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_slot(res_slot),
    .res_data(res_data), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .status(status), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, return at next negedge
  task automatic wr(input int a, input int d);
    reg_wr = 1; reg_addr = 5'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic strobe(input int s, input int v);
    res_valid = 1; res_slot = 3'(s); res_data = 12'(v);
    @(negedge clk);
    res_valid = 0;
  endtask

  function automatic logic [15:0] model_hit(input int s, input int v);
    logic [15:0] m = '0;
    if (v > hi_v[s]) m[8 + s] = 1'b1;
    if (v < lo_v[s]) m[s] = 1'b1;
    return m;
  endfunction

  function automatic logic model_irq(input logic [15:0] f, input logic [1:0] en);
    return (en[0] && f[15:8] != 0) || (en[1] && f[7:0] != 0);
  endfunction

  task automatic rd(input string tag, input int a, input int exp);
    reg_addr = 5'(a);
    #1;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: reset values
    chk("R9 status", 32'(status), 0);
    chk("R9 irq", 32'(irq), 0);
    for (int s = 0; s < 8; s++) begin
      rd("R9 hi reset", s, 12'hFFF);
      rd("R9 lo reset", 8 + s, 0);
    end
    rd("R9 ctrl reset", 16, 0);
    for (int s = 0; s < 8; s++) begin
      strobe(s, 0); strobe(s, 4095);
    end
    chk("R9 no flag under reset limits", 32'(status), 0);

    // R11: program and read back limits, upper bits dropped
    for (int s = 0; s < 8; s++) begin
      hi_v[s] = 1000 + 100 * s;
      lo_v[s] = 200 + 50 * s;
      wr(s, 16'hF000 | hi_v[s]);
      wr(8 + s, lo_v[s]);
    end
    for (int s = 0; s < 8; s++) begin
      rd("R11 hi readback", s, hi_v[s]);
      rd("R11 lo readback", 8 + s, lo_v[s]);
    end
    wr(16, 16'hFFFE);
    rd("R11 ctrl readback", 16, 2);
    wr(16, 0);

    // R1 R2 R3 R6: boundary sweep over every slot
    for (int s = 0; s < 8; s++) begin
      int vals [7];
      vals = '{lo_v[s] - 1, lo_v[s], hi_v[s], hi_v[s] + 1, (lo_v[s] + hi_v[s]) / 2, 0, 4095};
      for (int k = 0; k < 7; k++) begin
        wr(17, 16'hFFFF);
        strobe(s, vals[k]);
        exp_st = model_hit(s, vals[k]);
        chk("R1 R2 R3 R6 sweep", 32'(status), 32'(exp_st));
        rd("R6 status read", 17, exp_st);
      end
    end

    // R10: no change before the edge, change after it
    wr(17, 16'hFFFF);
    res_valid = 1; res_slot = 3'd4; res_data = 12'd4000;
    #1;
    chk("R10 before edge", 32'(status), 0);
    @(negedge clk);
    res_valid = 0;
    chk("R10 after edge", 32'(status), 32'h1000);

    // R4: sticky through in-range results
    strobe(4, 700);
    strobe(4, 800);
    chk("R4 sticky hi", 32'(status), 32'h1000);
    strobe(2, 10);
    strobe(2, 500);
    chk("R4 sticky lo", 32'(status), 32'h1004);

    // R5: zero write has no effect, partial clear
    wr(17, 0);
    chk("R5 zero write", 32'(status), 32'h1004);
    wr(17, 16'h0004);
    chk("R5 partial clear", 32'(status), 32'h1000);
    wr(17, 16'hEFFF);
    chk("R5 other bits", 32'(status), 32'h1000);
    wr(17, 16'h1000);
    chk("R5 full clear", 32'(status), 0);

    // R8: set wins over clear in one cycle, other bits still clear
    strobe(1, 0);
    chk("R8 prep", 32'(status), 32'h0002);
    res_valid = 1; res_slot = 3'd2; res_data = 12'd4095;
    reg_wr = 1; reg_addr = 5'd17; reg_wdata = 16'h0402;
    @(negedge clk);
    res_valid = 0; reg_wr = 0;
    chk("R8 set beats clear", 32'(status), 32'h0400);
    wr(17, 16'hFFFF);

    // R7: interrupt gating
    strobe(3, 4095);
    exp_st = 16'h0800;
    for (int e = 0; e < 4; e++) begin
      wr(16, e);
      chk("R7 irq hi only", 32'(irq), 32'(model_irq(exp_st, 2'(e))));
    end
    strobe(5, 0);
    exp_st = 16'h0820;
    for (int e = 0; e < 4; e++) begin
      wr(16, e);
      chk("R7 irq both", 32'(irq), 32'(model_irq(exp_st, 2'(e))));
    end
    wr(17, 16'h0800);
    exp_st = 16'h0020;
    for (int e = 0; e < 4; e++) begin
      wr(16, e);
      chk("R7 irq lo only", 32'(irq), 32'(model_irq(exp_st, 2'(e))));
    end
    chk("R7 status", 32'(status), 32'(exp_st));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule